// File: doc/BRIEF.md
# Cartridge Bank and Network-Controller Decoder

This block sits between the CPU bus of a 6502-based console and the memories and Ethernet controller of an expansion cartridge. It watches the $6000-$7FFF window and the /ROMSEL line. Two 4-bit bank registers live in the $6xxx page. A read there loads the PRG bank from the low four address lines, so no data is needed. A write there loads the CHR bank from the low four data lines. The $7xxx page produces active-low read and write strobes for a memory-mapped network controller. The $8000-$FFFF window is steered to one 32 KiB slice of either the boot flash or the PRG RAM.

All four internal strobes are qualified by M2. The controller strobes therefore fall only after the address has settled. A small state machine runs on a system clock faster than M2. It follows each access through the states ST_IDLE, ST_PRG_CAPTURE, ST_CHR_CAPTURE and ST_NIC_ACCESS:

- ST_IDLE goes to ST_PRG_CAPTURE on a $6xxx read strobe.
- ST_IDLE goes to ST_CHR_CAPTURE on a $6xxx write strobe.
- ST_IDLE goes to ST_NIC_ACCESS on either $7xxx strobe.
- Each busy state stays where it is while its strobe is low, and returns to ST_IDLE when the strobe is released.

While a capture state is held, the block samples its source on every clock. The held value is written into the bank register on the transition back to ST_IDLE. The new bank therefore appears one clock after the strobe rises, much like a discrete latch clocked at the end of the strobe.

Top module: `cart_nic_decoder`

## Requirements
- R1: While rst_n is low, and after it is released, both bank registers are zero: prg_addr is 0 and chr_addr is 0. With bank bit 3 at zero, the flash is the chip chosen for the high window.
- R2: A CPU read while M2 is high, /ROMSEL is high and A14..A12 = 110 loads A3..A0 into the PRG bank. The new value is visible on the outputs from the first clock edge at which that read strobe is inactive.
- R3: A CPU write under the same address conditions loads D3..D0 into the CHR bank. chr_addr (CHR A13..A16) shows the new value from the first clock edge after the write strobe ends.
- R4: PRG bank bit 3 chooses the chip. With bit 3 = 0, a CPU read with /ROMSEL low drives flash_ce_n low. With bit 3 = 1, an access with /ROMSEL low drives ram_ce_n low. The two enables are never low together.
- R5: prg_addr (PRG A15..A17) always equals PRG bank bits 2..0.
- R6: No strobe of any kind occurs unless M2 is high, /ROMSEL is high and A14 and A13 are both high. Accesses to $4xxx, $5xxx, the high window, or any access while M2 is low leave nic_rd_n and nic_wr_n high and leave both banks unchanged.
- R7: A read with A14..A12 = 111 under the window conditions drives nic_rd_n low, and a write drives nic_wr_n low. Such accesses change neither bank register.
- R8: ram_we_n is low only when /ROMSEL is low, R/W is low and PRG bank bit 3 is 1. flash_ce_n is never low during a write, so the flash cannot be written through the high window.
- R9: A $6xxx write leaves the PRG bank unchanged, and a $6xxx read leaves the CHR bank unchanged. If the source lines change while a strobe is held, the value present on the last clock of the strobe is the one loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than M2 |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cpu_a_lo | input | 4 | CPU address bits A3..A0 |
| cpu_a_hi | input | 3 | CPU address bits A14..A12 (bit 2 = A14) |
| cpu_data | input | 4 | CPU data bits D3..D0 |
| cpu_rw | input | 1 | CPU R/W, 1 = read |
| cpu_m2 | input | 1 | CPU M2 phase, high during the valid phase |
| cpu_romsel_n | input | 1 | Active-low select of $8000-$FFFF, already qualified by M2 |
| prg_addr | output | 3 | PRG A15..A17 from PRG bank bits 2..0 |
| flash_ce_n | output | 1 | Boot flash chip enable, active low, reads only |
| ram_ce_n | output | 1 | PRG RAM chip enable, active low |
| ram_we_n | output | 1 | PRG RAM write enable, active low |
| chr_addr | output | 4 | CHR A13..A16 from the CHR bank |
| nic_rd_n | output | 1 | Network controller read strobe for $7xxx, active low |
| nic_wr_n | output | 1 | Network controller write strobe for $7xxx, active low |

## Verification
Some properties are checked on every cycle:
- The chip enables are mutually exclusive.
- The RAM write enable never appears without the RAM chip enable.
- The controller strobes stay high while M2 is low, and never fall together.
- A bank register changes only on the clock after its own capture state.
- The PRG bank holds still while a CHR capture is in progress.

Other behaviour can only be shown by the bench's scenarios:
- The actual values loaded into the banks.
- The rule that the last held value wins when the source lines change mid-strobe.
- That $7xxx and out-of-window accesses leave the banks alone.
- That the flash and RAM windows open in step with each bank change.

// File: rtl/cart_pkg.sv
package cart_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRG_CAPTURE,
        ST_CHR_CAPTURE,
        ST_NIC_ACCESS
    } cart_state_e;

    localparam int NUM_STROBES = 4;
    localparam int STB_RD6 = 0;
    localparam int STB_WR6 = 1;
    localparam int STB_RD7 = 2;
    localparam int STB_WR7 = 3;
endpackage

// File: rtl/cart_strobe_decode.sv
module cart_strobe_decode
    import cart_pkg::*;
(
    input  logic                   m2,
    input  logic                   romsel_n,
    input  logic [2:0]             a_hi,
    input  logic                   rw,
    output logic [NUM_STROBES-1:0] strobe_n
);
    logic win_sel;

    // $6000-$7FFF during the valid phase only
    assign win_sel = m2 & romsel_n & a_hi[2] & a_hi[1];

    // index bit 1 = A12, index bit 0 = write
    for (genvar gi = 0; gi < NUM_STROBES; gi++) begin : g_strobe
        localparam logic PAGE7 = ((gi / 2) == 1);
        localparam logic IS_WR = ((gi % 2) == 1);
        assign strobe_n[gi] = ~(win_sel & (a_hi[0] == PAGE7) & (rw == ~IS_WR));
    end
endmodule

// File: rtl/cart_bank_fsm.sv
module cart_bank_fsm
    import cart_pkg::*;
#(
    parameter int PRG_BANK_W = 4,
    parameter int CHR_BANK_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_STROBES-1:0] strobe_n,
    input  logic [PRG_BANK_W-1:0]  a_lo,
    input  logic [CHR_BANK_W-1:0]  data,
    output logic [PRG_BANK_W-1:0]  prg_bank,
    output logic [CHR_BANK_W-1:0]  chr_bank
);
    cart_state_e state, next_state;
    logic [PRG_BANK_W-1:0] prg_hold;
    logic [CHR_BANK_W-1:0] chr_hold;
    logic cap_prg, cap_chr, commit_prg, commit_chr;
    logic rd6, wr6, nic_any;

    assign rd6     = ~strobe_n[STB_RD6];
    assign wr6     = ~strobe_n[STB_WR6];
    assign nic_any = ~strobe_n[STB_RD7] | ~strobe_n[STB_WR7];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    // next state and capture/commit controls
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE: begin
                if (rd6)          next_state = ST_PRG_CAPTURE;
                else if (wr6)     next_state = ST_CHR_CAPTURE;
                else if (nic_any) next_state = ST_NIC_ACCESS;
                else              next_state = ST_IDLE;
            end
            ST_PRG_CAPTURE: next_state = rd6     ? ST_PRG_CAPTURE : ST_IDLE;
            ST_CHR_CAPTURE: next_state = wr6     ? ST_CHR_CAPTURE : ST_IDLE;
            ST_NIC_ACCESS:  next_state = nic_any ? ST_NIC_ACCESS  : ST_IDLE;
            default:        next_state = ST_IDLE;
        endcase
        cap_prg    = (next_state == ST_PRG_CAPTURE);
        cap_chr    = (next_state == ST_CHR_CAPTURE);
        commit_prg = (state == ST_PRG_CAPTURE) && !cap_prg;
        commit_chr = (state == ST_CHR_CAPTURE) && !cap_chr;
    end

    // hold and bank registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prg_hold <= '0;
            chr_hold <= '0;
            prg_bank <= '0;
            chr_bank <= '0;
        end else begin
            if (cap_prg)    prg_hold <= a_lo;
            if (cap_chr)    chr_hold <= data;
            if (commit_prg) prg_bank <= prg_hold;
            if (commit_chr) chr_bank <= chr_hold;
        end
    end

    p_prg_after_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prg_bank) |-> $past(state) == ST_PRG_CAPTURE);
    p_chr_after_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chr_bank) |-> $past(state) == ST_CHR_CAPTURE);
    p_prg_held_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHR_CAPTURE) |=> $stable(prg_bank));
    p_banks_held_by_nic_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NIC_ACCESS) |=> ($stable(prg_bank) && $stable(chr_bank)));
endmodule

// File: rtl/cart_window_map.sv
module cart_window_map #(
    parameter int PRG_BANK_W = 4,
    parameter int PRG_ADDR_W = PRG_BANK_W - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  romsel_n,
    input  logic                  rw,
    input  logic [PRG_BANK_W-1:0] prg_bank,
    output logic [PRG_ADDR_W-1:0] prg_addr,
    output logic                  flash_ce_n,
    output logic                  ram_ce_n,
    output logic                  ram_we_n
);
    localparam int CHIP_BIT = PRG_BANK_W - 1;

    logic use_ram;
    assign use_ram    = prg_bank[CHIP_BIT];
    assign prg_addr   = prg_bank[PRG_ADDR_W-1:0];
    assign flash_ce_n = ~(~romsel_n & ~use_ram & rw);
    assign ram_ce_n   = ~(~romsel_n & use_ram);
    assign ram_we_n   = ~(~romsel_n & use_ram & ~rw);

    p_chip_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_ce_n && !ram_ce_n));
    p_we_needs_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> !ram_ce_n);
    p_flash_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_ce_n |-> rw);
endmodule

// File: rtl/cart_nic_decoder.sv
module cart_nic_decoder
    import cart_pkg::*;
#(
    parameter int PRG_BANK_W = 4,
    parameter int CHR_BANK_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PRG_BANK_W-1:0] cpu_a_lo,
    input  logic [2:0]            cpu_a_hi,
    input  logic [CHR_BANK_W-1:0] cpu_data,
    input  logic                  cpu_rw,
    input  logic                  cpu_m2,
    input  logic                  cpu_romsel_n,
    output logic [PRG_BANK_W-2:0] prg_addr,
    output logic                  flash_ce_n,
    output logic                  ram_ce_n,
    output logic                  ram_we_n,
    output logic [CHR_BANK_W-1:0] chr_addr,
    output logic                  nic_rd_n,
    output logic                  nic_wr_n
);
    localparam int PRG_ADDR_W = PRG_BANK_W - 1;

    logic [NUM_STROBES-1:0] strobe_n;
    logic [PRG_BANK_W-1:0]  prg_bank;
    logic [CHR_BANK_W-1:0]  chr_bank;

    cart_strobe_decode u_decode (
        .m2       (cpu_m2),
        .romsel_n (cpu_romsel_n),
        .a_hi     (cpu_a_hi),
        .rw       (cpu_rw),
        .strobe_n (strobe_n)
    );

    cart_bank_fsm #(.PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .a_lo     (cpu_a_lo),
        .data     (cpu_data),
        .prg_bank (prg_bank),
        .chr_bank (chr_bank)
    );

    cart_window_map #(.PRG_BANK_W(PRG_BANK_W), .PRG_ADDR_W(PRG_ADDR_W)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .romsel_n   (cpu_romsel_n),
        .rw         (cpu_rw),
        .prg_bank   (prg_bank),
        .prg_addr   (prg_addr),
        .flash_ce_n (flash_ce_n),
        .ram_ce_n   (ram_ce_n),
        .ram_we_n   (ram_we_n)
    );

    assign chr_addr = chr_bank;
    assign nic_rd_n = strobe_n[STB_RD7];
    assign nic_wr_n = strobe_n[STB_WR7];

    p_nic_needs_m2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_m2 |-> (nic_rd_n && nic_wr_n));
    p_nic_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nic_rd_n && !nic_wr_n));
    p_nic_outside_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_romsel_n |-> (nic_rd_n && nic_wr_n));
endmodule

// File: tb/cart_nic_decoder_bench.sv
module cart_nic_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cpu_a_lo = '0;
    logic [2:0] cpu_a_hi = '0;
    logic [3:0] cpu_data = '0;
    logic       cpu_rw = 1'b1;
    logic       cpu_m2 = 1'b0;
    logic       cpu_romsel_n = 1'b1;
    logic [2:0] prg_addr;
    logic       flash_ce_n, ram_ce_n, ram_we_n, nic_rd_n, nic_wr_n;
    logic [3:0] chr_addr;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit running = 1'b1;

    // behavioural reference state
    int m_prg = 0, m_chr = 0, p_pend = 0, c_pend = 0;
    bit p_busy = 0, c_busy = 0;

    cart_nic_decoder u_cart_nic_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_a_lo(cpu_a_lo), .cpu_a_hi(cpu_a_hi),
        .cpu_data(cpu_data), .cpu_rw(cpu_rw), .cpu_m2(cpu_m2),
        .cpu_romsel_n(cpu_romsel_n), .prg_addr(prg_addr), .flash_ce_n(flash_ce_n),
        .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .chr_addr(chr_addr),
        .nic_rd_n(nic_rd_n), .nic_wr_n(nic_wr_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // reference update on each clock edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_prg = 0; m_chr = 0; p_busy = 0; c_busy = 0;
        end else begin
            bit win;
            win = cpu_m2 && cpu_romsel_n && cpu_a_hi[2] && cpu_a_hi[1] && !cpu_a_hi[0];
            if (win && cpu_rw) begin
                p_pend = cpu_a_lo; p_busy = 1;
            end else if (p_busy) begin
                m_prg = p_pend; p_busy = 0;
            end
            if (win && !cpu_rw) begin
                c_pend = cpu_data; c_busy = 1;
            end else if (c_busy) begin
                m_chr = c_pend; c_busy = 0;
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && running) begin
            bit in7, hi_sel, ram;
            in7    = cpu_m2 && cpu_romsel_n && (cpu_a_hi == 3'b111);
            hi_sel = !cpu_romsel_n;
            ram    = (m_prg / 8) == 1;
            check("R5", "prg_addr", prg_addr, m_prg % 8);
            check("R3", "chr_addr", chr_addr, m_chr);
            check("R4", "flash_ce_n", flash_ce_n, (hi_sel && !ram && cpu_rw) ? 0 : 1);
            check("R4", "ram_ce_n", ram_ce_n, (hi_sel && ram) ? 0 : 1);
            check("R8", "ram_we_n", ram_we_n, (hi_sel && ram && !cpu_rw) ? 0 : 1);
            check("R7", "nic_rd_n", nic_rd_n, (in7 && cpu_rw) ? 0 : 1);
            check("R6", "nic_wr_n", nic_wr_n, (in7 && !cpu_rw) ? 0 : 1);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // one CPU cycle: 2 clocks with M2 low, 3 with M2 high
    task automatic cpu_cycle(input logic [15:0] addr, input logic rw, input logic [3:0] d);
        tick();
        cpu_m2 = 0; cpu_romsel_n = 1;
        cpu_a_lo = addr[3:0]; cpu_a_hi = addr[14:12];
        cpu_rw = rw; cpu_data = d;
        tick();
        cpu_m2 = 1; cpu_romsel_n = !addr[15];
        repeat (3) tick();
        cpu_m2 = 0; cpu_romsel_n = 1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            tick();
            cpu_m2 = 0; cpu_romsel_n = 1; cpu_rw = 1;
        end
    endtask

    initial begin
        repeat (3) tick();
        @(negedge clk);
        check("R1", "prg_addr in reset", prg_addr, 0);
        check("R1", "chr_addr in reset", chr_addr, 0);
        rst_n = 1;
        idle(2);
        @(negedge clk);
        check("R1", "prg_addr after reset", prg_addr, 0);
        check("R1", "flash chosen after reset", ram_ce_n, 1);

        cpu_cycle(16'h6005, 1, 4'h0); idle(2);
        @(negedge clk); check("R2", "prg load 5", prg_addr, 5);
        cpu_cycle(16'h6A3C, 0, 4'h9); idle(2);
        @(negedge clk); check("R3", "chr load 9", chr_addr, 9);
        check("R9", "prg after chr write", prg_addr, 5);
        cpu_cycle(16'h6FFE, 1, 4'h3); idle(2);
        @(negedge clk); check("R9", "chr after prg read", chr_addr, 9);

        cpu_cycle(16'h8123, 1, 4'h0);
        cpu_cycle(16'hC000, 0, 4'h7);
        cpu_cycle(16'h7300, 1, 4'h0);
        cpu_cycle(16'h7FF1, 0, 4'h2); idle(2);
        @(negedge clk); check("R7", "prg after nic access", prg_addr, 6);
        check("R7", "chr after nic access", chr_addr, 9);
        cpu_cycle(16'h5007, 1, 4'h0);
        cpu_cycle(16'h4008, 0, 4'h1);
        cpu_cycle(16'hE00B, 1, 4'h0);
        cpu_cycle(16'hE00B, 0, 4'h4); idle(2);
        @(negedge clk); check("R6", "prg after out-of-window", prg_addr, 6);
        check("R6", "chr after out-of-window", chr_addr, 9);

        cpu_cycle(16'h600D, 1, 4'h0); idle(2);
        @(negedge clk); check("R4", "ram bank prg_addr", prg_addr, 5);
        cpu_cycle(16'h9000, 1, 4'h0);
        cpu_cycle(16'hA000, 0, 4'h5);
        cpu_cycle(16'hFFFC, 0, 4'h5);
        cpu_cycle(16'h600F, 1, 4'h0); idle(2);
        cpu_cycle(16'hB000, 0, 4'h1);
        cpu_cycle(16'h6003, 1, 4'h0); idle(2);
        cpu_cycle(16'h8000, 0, 4'h1);
        cpu_cycle(16'h8000, 1, 4'h1);

        // source changes mid-strobe: last held value wins
        tick(); cpu_m2 = 0; cpu_a_hi = 3'b110; cpu_a_lo = 4'h1; cpu_rw = 1;
        tick(); cpu_m2 = 1;
        tick(); cpu_a_lo = 4'hE;
        tick(); tick(); cpu_m2 = 0;
        idle(2);
        @(negedge clk); check("R9", "prg last value wins", prg_addr, 6);
        tick(); cpu_m2 = 0; cpu_a_hi = 3'b110; cpu_rw = 0; cpu_data = 4'h2;
        tick(); cpu_m2 = 1;
        tick(); cpu_data = 4'hB;
        tick(); tick(); cpu_m2 = 0;
        idle(2);
        @(negedge clk); check("R3", "chr last value wins", chr_addr, 11);

        // M2 low with a $6xxx address present does nothing
        tick(); cpu_a_hi = 3'b110; cpu_a_lo = 4'h2; cpu_rw = 1; cpu_m2 = 0;
        idle(3);
        @(negedge clk); check("R6", "no load without M2", prg_addr, 6);

        idle(2);
        running = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > WATCHDOG);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule